// File: doc/BRIEF.md
# Temperature Limit Alert Controller

This block watches a stream of signed 12-bit temperature results (1/16 °C per LSB, two's complement) and decides when a thermal alert output should be active. Each result arrives with a one-cycle strobe. The block compares it, as a signed number, with a programmable high limit and a programmable low limit. A run of consecutive qualifying results is needed before the alert changes state. The configured fault-queue depth sets the length of that run.

Two behaviours are available. In hysteretic comparator mode the alert follows the temperature: it turns on after a run at or above the high limit and turns off after a run below the low limit. In latched interrupt mode a trip turns the alert on, and the alert stays on until a register-read pulse arrives. The next trip then waits for the opposite threshold, so high and low events alternate. A shutdown level clears everything. A polarity input selects whether the pin is active high or active low.

Top module: `therm_alert`

## Requirements
- R1: Alert state and the consecutive counter change only on a clock where `conv_done` is 1. The only other causes of change are a read pulse in interrupt mode, shutdown, and reset. Temperature changes without a strobe have no effect.
- R2: A result counts toward setting when signed `conv_temp >= lim_hi`, so equality qualifies. It counts toward clearing when signed `conv_temp < lim_lo`, so equality with the low limit does not qualify.
- R3: `fq_sel` sets the run length needed: 0 needs 1, 1 needs 2, 2 needs 4, 3 needs 6 consecutive qualifying results.
- R4: With `intr_mode`=0, an inactive alert becomes active after the run at or above the high limit. An active alert becomes inactive after the run below the low limit. Results between the limits keep the current state, and `reg_rd` has no effect.
- R5: With `intr_mode`=1, a trip makes the alert active, and it stays active until a clock with `reg_rd`=1. If a trip lands on the same clock as the read, the alert stays active.
- R6: In interrupt mode the watched threshold swaps at every trip. After a high trip the next trip needs a run below the low limit. After that, the next trip needs a run at or above the high limit again.
- R7: A strobed result that does not qualify for the threshold currently watched resets the run count to zero. A trip also resets it to zero.
- R8: The run count never exceeds 6.
- R9: While `shdn`=1, the alert is inactive and the run count is zero from the next clock on. Strobed results are ignored. The interrupt sequence restarts by watching the high limit.
- R10: `pol_high`=0 drives `alert_pin` low when the alert is active. `pol_high`=1 drives it high. After reset the alert is inactive.
- R11: Comparisons are signed. For example D80h (−40 °C) is below 190h (25 °C).
- R12: The package provides default limit constants of 75 °C (low, 4B0h) and 80 °C (high, 500h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a new result is on `conv_temp` |
| conv_temp | input | 12 | Signed temperature result, 1/16 °C per LSB |
| lim_lo | input | 12 | Signed low (clearing) limit |
| lim_hi | input | 12 | Signed high (setting) limit |
| intr_mode | input | 1 | 0 = hysteretic comparator, 1 = latched interrupt |
| pol_high | input | 1 | 1 = alert pin active high, 0 = active low |
| fq_sel | input | 2 | Fault-queue depth select (1/2/4/6) |
| reg_rd | input | 1 | Register-read pulse; clears a latched interrupt |
| shdn | input | 1 | Shutdown level; clears alert and counter |
| alert_pin | output | 1 | Alert output level |

## Verification
The bench hits each threshold exactly, at the limit itself and one LSB to either side. A design using `>` for the high limit or `<=` for the low limit would set or clear one LSB late or early. Runs are broken one result short of each queue depth, so a counter that did not restart on a miss, or that decoded depth 3 as 8, would trip at the wrong result. Interrupt sequences place a read on the same clock as a trip. They also check that a high trip is not followed by another high trip; a design that cleared the trip or forgot to swap thresholds would show the wrong level. Limits chosen around zero expose an unsigned comparison, and shutdown during an active alert shows whether clearing and re-arming happen.

// File: rtl/therm_alert_pkg.sv
package therm_alert_pkg;

    localparam int TEMP_W = 12;
    localparam int FQ_MAX = 6;
    localparam int CNT_W  = $clog2(FQ_MAX + 1);

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef enum logic [1:0] {
        FQ_ONE  = 2'd0,
        FQ_TWO  = 2'd1,
        FQ_FOUR = 2'd2,
        FQ_SIX  = 2'd3
    } fq_sel_e;

    typedef struct packed {
        logic active;    // alert currently asserted (polarity-free)
        logic arm_high;  // interrupt mode: next trip watches the high limit
    } alert_state_t;

    // 75 C and 80 C at 1/16 C per LSB
    localparam temp_t LIMIT_LO_DEFAULT = temp_t'(75 * 16);
    localparam temp_t LIMIT_HI_DEFAULT = temp_t'(80 * 16);

    function automatic logic [CNT_W-1:0] fq_need(input logic [1:0] sel);
        case (fq_sel_e'(sel))
            FQ_ONE:  return CNT_W'(1);
            FQ_TWO:  return CNT_W'(2);
            FQ_FOUR: return CNT_W'(4);
            default: return CNT_W'(FQ_MAX);
        endcase
    endfunction

endpackage

// File: rtl/therm_fault_qual.sv
module therm_fault_qual #(
    parameter int TW = 12
) (
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] lo,
    input  logic [TW-1:0] hi,
    input  logic          watch_high,
    output logic          qualifies
);
    always_comb begin
        if (watch_high) qualifies = ($signed(temp) >= $signed(hi));
        else            qualifies = ($signed(temp) <  $signed(lo));
    end
endmodule

// File: rtl/therm_fault_cnt.sv
module therm_fault_cnt #(
    parameter int CW  = 3,
    parameter int SAT = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic          qualifies,
    input  logic [CW-1:0] need,
    output logic          trip,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] SAT_V = CW'(SAT);

    logic [CW-1:0] nxt;

    always_comb begin
        nxt  = (count >= SAT_V) ? SAT_V : count + 1'b1;
        trip = step && qualifies && (nxt >= need);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (step) begin
            if (!qualifies || trip) count <= '0;
            else                    count <= nxt;
        end
    end
endmodule

// File: rtl/therm_alert_fsm.sv
module therm_alert_fsm
    import therm_alert_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shdn,
    input  logic intr_mode,
    input  logic trip,
    input  logic reg_rd,
    output logic alert_act,
    output logic watch_high
);
    alert_state_t st;

    always_ff @(posedge clk) begin
        if (rst || shdn) begin
            st.active   <= 1'b0;
            st.arm_high <= 1'b1;
        end else if (intr_mode) begin
            if (trip) begin
                st.active   <= 1'b1;
                st.arm_high <= ~st.arm_high;
            end else if (reg_rd) begin
                st.active   <= 1'b0;
            end
        end else if (trip) begin
            st.active <= ~st.active;
        end
    end

    assign alert_act  = st.active;
    assign watch_high = intr_mode ? st.arm_high : ~st.active;
endmodule

// File: rtl/therm_alert.sv
module therm_alert
    import therm_alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [TEMP_W-1:0] conv_temp,
    input  logic [TEMP_W-1:0] lim_lo,
    input  logic [TEMP_W-1:0] lim_hi,
    input  logic              intr_mode,
    input  logic              pol_high,
    input  logic [1:0]        fq_sel,
    input  logic              reg_rd,
    input  logic              shdn,
    output logic              alert_pin
);
    logic             watch_high;
    logic             qual;
    logic             trip;
    logic             alert_act;
    logic [CNT_W-1:0] fault_cnt;
    logic [CNT_W-1:0] need;

    assign need = fq_need(fq_sel);

    therm_fault_qual #(.TW(TEMP_W)) u_qual (
        .temp       (conv_temp),
        .lo         (lim_lo),
        .hi         (lim_hi),
        .watch_high (watch_high),
        .qualifies  (qual)
    );

    therm_fault_cnt #(.CW(CNT_W), .SAT(FQ_MAX)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (shdn),
        .step      (conv_done),
        .qualifies (qual),
        .need      (need),
        .trip      (trip),
        .count     (fault_cnt)
    );

    therm_alert_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .shdn       (shdn),
        .intr_mode  (intr_mode),
        .trip       (trip),
        .reg_rd     (reg_rd),
        .alert_act  (alert_act),
        .watch_high (watch_high)
    );

    assign alert_pin = pol_high ? alert_act : ~alert_act;
endmodule

// File: rtl/therm_alert_chk.sv
module therm_alert_chk
    import therm_alert_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             shdn,
    input logic             conv_done,
    input logic             reg_rd,
    input logic             intr_mode,
    input logic             qual,
    input logic             alert_act,
    input logic [CNT_W-1:0] fault_cnt
);
    AST_SHDN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        shdn |=> (!alert_act && fault_cnt == '0)); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fault_cnt <= CNT_W'(FQ_MAX)); // R8

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && !reg_rd && !shdn) |=> $stable(alert_act)); // R1

    AST_ALERT_RISE_ON_CONV: assert property (@(posedge clk) disable iff (rst)
        $rose(alert_act) |-> $past(conv_done)); // R1

    AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (intr_mode && alert_act && !reg_rd && !shdn) |=> alert_act); // R5

    AST_MISS_RESETS_CNT: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !qual && !shdn) |=> fault_cnt == '0); // R7
endmodule

bind therm_alert therm_alert_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .shdn      (shdn),
    .conv_done (conv_done),
    .reg_rd    (reg_rd),
    .intr_mode (intr_mode),
    .qual      (qual),
    .alert_act (alert_act),
    .fault_cnt (fault_cnt)
);

// File: tb/therm_alert_tb.sv
module therm_alert_tb;
    import therm_alert_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0;
    logic [11:0] conv_temp = '0;
    logic [11:0] lim_lo = LIMIT_LO_DEFAULT;
    logic [11:0] lim_hi = LIMIT_HI_DEFAULT;
    logic        intr_mode = 1'b0;
    logic        pol_high = 1'b0;
    logic [1:0]  fq_sel = 2'd0;
    logic        reg_rd = 1'b0;
    logic        shdn = 1'b0;
    logic        alert_pin;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_req = "R10";

    int m_act = 0;
    int m_cnt = 0;
    int m_arm = 1;

    always #5 clk = ~clk;

    therm_alert u_dut (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_temp(conv_temp),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .intr_mode(intr_mode),
        .pol_high(pol_high), .fq_sel(fq_sel), .reg_rd(reg_rd), .shdn(shdn),
        .alert_pin(alert_pin)
    );

    function automatic int run_len(logic [1:0] f);
        case (f)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 6;
        endcase
    endfunction

    task automatic check(string req, logic got, logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: alert_pin=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // one clock: drive inputs, step the reference model, compare after the edge
    task automatic cyc(bit cd, logic [11:0] t, bit rd, bit sd);
        int  ti, lo_i, hi_i;
        bit  look_hi, q, tripped;
        conv_done = cd; conv_temp = t; reg_rd = rd; shdn = sd;
        tripped = 0;
        if (rst) begin
            m_act = 0; m_cnt = 0; m_arm = 1;
        end else if (sd) begin
            m_act = 0; m_cnt = 0; m_arm = 1;
        end else begin
            if (cd) begin
                ti   = int'($signed(t));
                lo_i = int'($signed(lim_lo));
                hi_i = int'($signed(lim_hi));
                look_hi = intr_mode ? (m_arm != 0) : (m_act == 0);
                q = look_hi ? (ti >= hi_i) : (ti < lo_i);
                if (q) begin
                    m_cnt++;
                    if (m_cnt >= run_len(fq_sel)) begin
                        tripped = 1;
                        m_cnt = 0;
                        if (intr_mode) begin m_act = 1; m_arm = (m_arm == 0); end
                        else m_act = (m_act == 0);
                    end
                end else begin
                    m_cnt = 0;
                end
            end
            if (intr_mode && rd && !tripped) m_act = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check(cur_req, alert_pin, pol_high ? (m_act != 0) : (m_act == 0));
    endtask

    task automatic conv(logic [11:0] t);
        cyc(1, t, 0, 0);
    endtask

    task automatic idle();
        cyc(0, conv_temp, 0, 0);
    endtask

    task automatic read_pulse();
        cyc(0, conv_temp, 1, 0);
    endtask

    task automatic shut(int n);
        for (int i = 0; i < n; i++) cyc(1, 12'h7FF, 0, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        @(negedge clk);
        cyc(0, 12'h000, 0, 0);
        cyc(0, 12'h000, 0, 0);
        rst = 1'b0;
        // R10: reset state inactive, active-low pin reads 1
        cur_req = "R10";
        idle();

        // R12: default limits 75 C and 80 C
        n_cmp++;
        if (LIMIT_LO_DEFAULT !== 12'h4B0 || LIMIT_HI_DEFAULT !== 12'h500) begin
            n_bad++;
            $display("FAIL R12: limits %h/%h expected 4b0/500", LIMIT_LO_DEFAULT, LIMIT_HI_DEFAULT);
        end

        // R2 / R4: exact threshold edges in comparator mode, depth 1
        cur_req = "R2";
        conv(12'h4FF); conv(12'h500);
        cur_req = "R4";
        conv(12'h4B0); conv(12'h300); conv(12'h4B0);
        read_pulse();
        cur_req = "R2";
        conv(12'h4AF);
        conv(12'h4FF);

        // R1: temperature moves without a strobe
        cur_req = "R1";
        cyc(0, 12'h7F0, 0, 0); cyc(0, 12'h7F0, 0, 0); idle();

        // R3 / R7: depth 2, 4 and 6 with broken runs
        cur_req = "R3";
        fq_sel = 2'd1;
        conv(12'h500); idle(); conv(12'h500);
        conv(12'h100); conv(12'h4C0); conv(12'h100);
        fq_sel = 2'd0; conv(12'h100);
        cur_req = "R7";
        fq_sel = 2'd2;
        conv(12'h600); conv(12'h600); conv(12'h600); conv(12'h4FF);
        conv(12'h600); conv(12'h600); conv(12'h600); conv(12'h600);
        conv(12'h100); conv(12'h100); conv(12'h100); conv(12'h4B0);
        for (int i = 0; i < 4; i++) conv(12'h100);
        cur_req = "R8";
        fq_sel = 2'd3;
        for (int i = 0; i < 5; i++) conv(12'h700);
        conv(12'h000);
        for (int i = 0; i < 7; i++) conv(12'h700);
        for (int i = 0; i < 6; i++) conv(12'h000);

        // R11: limits around zero
        cur_req = "R11";
        fq_sel = 2'd0;
        lim_hi = 12'h190; lim_lo = 12'h000;
        conv(12'hD80); conv(12'h190); conv(12'h000); conv(12'hD80);
        lim_lo = 12'hD80; lim_hi = 12'hFFC;
        conv(12'hFFC); conv(12'hD80); conv(12'hD7F);

        // R5 / R6: interrupt mode
        lim_lo = LIMIT_LO_DEFAULT; lim_hi = LIMIT_HI_DEFAULT;
        shut(1);
        intr_mode = 1'b1;
        cur_req = "R5";
        conv(12'h500); conv(12'h600); idle(); conv(12'h300);
        read_pulse();
        cur_req = "R6";
        conv(12'h600); conv(12'h600); conv(12'h4B0); conv(12'h4AF);
        read_pulse();
        conv(12'h100);
        cur_req = "R5";
        cyc(1, 12'h500, 1, 0);
        idle(); read_pulse();
        cur_req = "R6";
        fq_sel = 2'd1;
        conv(12'h100); conv(12'h600); conv(12'h100); conv(12'h100);
        read_pulse();

        // R9: shutdown during an active alert, then restart on the high limit
        cur_req = "R9";
        fq_sel = 2'd0;
        conv(12'h700);
        shut(3);
        idle();
        conv(12'h100); conv(12'h700);
        shut(1);
        intr_mode = 1'b0;
        conv(12'h700); shut(2); conv(12'h4B0);

        // R10: active-high pin
        cur_req = "R10";
        pol_high = 1'b1;
        idle(); conv(12'h600); conv(12'h000); idle();

        // mixed pseudo-random sweep against the model
        cur_req = "R4";
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[3:0] == 4'h0) intr_mode = ~intr_mode;
            if (lf[7:4] == 4'h5) pol_high = ~pol_high;
            fq_sel = lf[9:8];
            cur_req = intr_mode ? "R5" : "R4";
            cyc(lf[10] | lf[11], 12'h490 + {4'h0, lf[15:11], 3'b0}, lf[12] & lf[2],
                (lf[14:12] == 3'b111) && lf[1]);
        end

        summary();
        $finish;
    end
endmodule